// File: doc/BRIEF.md
# Coprocessor Host Control/Status Register Pair

This block sits between a host I/O bus and a network coprocessor card. It decodes two register addresses inside a four-word window. The window's base is picked from four fixed values by a two-bit board-select input. A write to the control address updates the flags that hold the local processor in halt and reset. The same write drives the local processor's interrupt lines and sets the enable for interrupts towards the host. A read of the status address returns the configured shared-memory bank number together with the live halt, reset, pending and enable flags.

A host master clear or a power-on reset parks the local processor in halt and reset. The host starts the local processor by writing the control register with both of those bits at zero. The local processor asks for host attention by pulsing a set input. That input latches a pending flag, which the host clears by writing control bit 2 as zero. The host interrupt line is raised only while that flag is pending and the host-side enable is set.

Top module: `nic_hcsr`

## Requirements
- R1: With board select s, the base is 0o140360 + 4*s. The control register answers at base+1 and base+3, and the status register answers at base+0 and base+2. Other addresses reach neither register.
- R2: Reset and master clear (`mclr_i`) both set halt and reset and clear every other control flag. Master clear wins over a control write or a pending-set pulse in the same cycle.
- R3: Control bit 5 writes halt and bit 4 writes reset. A write with both at zero releases `lp_halt_o` and `lp_reset_o` from the following cycle.
- R4: Control bit 8 drives `chk_dis_o`, bit 6 is the power-low flag and bit 3 is the operator-command flag. Bits 15..9, 7 and 1 are ignored.
- R5: `lp_ipl_o` is 7 while power-low is set, otherwise 6 while operator-command is set, otherwise 0.
- R6: A pulse on `lp_irq_set_i` sets the pending flag. A control write with bit 2 at zero clears it, and a write with bit 2 at one leaves it unchanged. A set in the same cycle as a clearing write leaves the flag set.
- R7: `host_irq_o` is high exactly while the pending flag and the enable flag (control bit 0) are both set.
- R8: Status layout: bits 15..10 carry `bank_i[7:2]`, bits 9..8 read 0, bit 5 is halt, bit 4 is reset, bit 2 is pending and bit 0 is enable. Bits 7, 6, 3 and 1 read 0.
- R9: A write to a status address and a read of a control address have no effect and return 0. `rdata_o` is 0 whenever no status read is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mclr_i | input | 1 | Host master clear, synchronous |
| sel_i | input | 2 | Board select, picks the base address |
| addr_i | input | 16 | Host I/O address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| bank_i | input | 8 | Configured memory bank number |
| lp_irq_set_i | input | 1 | Local processor request to interrupt the host |
| lp_halt_o | output | 1 | Halt to local processor |
| lp_reset_o | output | 1 | Reset to local processor |
| lp_ipl_o | output | 3 | Interrupt priority level to local processor |
| chk_dis_o | output | 1 | Check-bit disable |
| host_irq_o | output | 1 | Interrupt request to host |

## Verification
The pending flag has two writers that can act in the same cycle: the local processor's set pulse and a host control write with bit 2 at zero. The bench drives both in one clock and expects the flag to stay set and the host interrupt line to rise. It then confirms that a later clearing write on its own drops the line. Master clear is raised together with a start write, and the bench expects halt and reset to remain asserted.

// File: rtl/nic_hcsr_pkg.sv
package nic_hcsr_pkg;
  localparam int DATA_W = 16;

  // control / status bit positions
  localparam int B_EN    = 0;
  localparam int B_HIRQ  = 2;
  localparam int B_OPCOM = 3;
  localparam int B_RST   = 4;
  localparam int B_HALT  = 5;
  localparam int B_PWRL  = 6;
  localparam int B_CHKD  = 8;

  localparam logic [2:0] IPL_PWRL  = 3'd7;
  localparam logic [2:0] IPL_OPCOM = 3'd6;
  localparam logic [2:0] IPL_NONE  = 3'd0;

  typedef struct packed {
    logic halt;
    logic rst;
    logic chk_dis;
    logic pwr_low;
    logic opcom;
    logic pend;
    logic en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{halt: 1'b1, rst: 1'b1, chk_dis: 1'b0,
                                 pwr_low: 1'b0, opcom: 1'b0, pend: 1'b0,
                                 en: 1'b0};
endpackage

// File: rtl/nic_hcsr_decode.sv
module nic_hcsr_decode #(
  parameter int ADDR_W    = 16,
  parameter int SEL_W     = 2,
  parameter int BASE_ADDR = 'o140360,
  parameter int STRIDE    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ctrl_hit_o,
  output logic              stat_hit_o
);
  localparam int NUM_SEL = 1 << SEL_W;

  logic [ADDR_W-1:0] base_tbl [NUM_SEL];
  logic [ADDR_W-1:0] off;
  logic              in_win;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_base
    assign base_tbl[g] = ADDR_W'(BASE_ADDR + g * STRIDE);
  end

  assign off        = addr_i - base_tbl[sel_i];
  assign in_win     = off < ADDR_W'(4);
  assign ctrl_hit_o = in_win &&  off[0];
  assign stat_hit_o = in_win && !off[0];

  // R1
  hit_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_hit_o, stat_hit_o}));
endmodule

// File: rtl/nic_hcsr_ctrl.sv
module nic_hcsr_ctrl
  import nic_hcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_set_i,
  output ctrl_t             q_o
);
  ctrl_t q;
  logic  unused_wbits;

  assign unused_wbits = ^{wdata_i[DATA_W-1:B_CHKD+1], wdata_i[B_CHKD-1], wdata_i[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= CTRL_RST;
    end else if (mclr_i) begin
      q <= CTRL_RST;
    end else begin
      if (wr_en_i) begin
        q.halt    <= wdata_i[B_HALT];
        q.rst     <= wdata_i[B_RST];
        q.chk_dis <= wdata_i[B_CHKD];
        q.pwr_low <= wdata_i[B_PWRL];
        q.opcom   <= wdata_i[B_OPCOM];
        q.en      <= wdata_i[B_EN];
      end
      if (wr_en_i && !wdata_i[B_HIRQ]) q.pend <= 1'b0;
      if (irq_set_i)                   q.pend <= 1'b1; // set wins
    end
  end

  assign q_o = q;

  // R2
  mclr_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclr_i |=> (q.halt && q.rst && !q.pend && !q.en));
  // R3
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mclr_i && !wdata_i[B_HALT] && !wdata_i[B_RST]) |=> (!q.halt && !q.rst));
  // R6
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_set_i && !mclr_i) |=> q.pend);
  // R6
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wdata_i[B_HIRQ] && !irq_set_i) |=> !q.pend);
endmodule

// File: rtl/nic_hcsr_stat.sv
module nic_hcsr_stat
  import nic_hcsr_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_hit_i,
  input  logic [BANK_W-1:0] bank_i,
  input  ctrl_t             q_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [2:0]        ipl_o
);
  localparam int LOW_W = DATA_W - BANK_W;

  logic [DATA_W-1:0] stat_word;
  logic [LOW_W-1:0]  low;
  logic              unused_bank;

  assign unused_bank = ^bank_i[1:0];

  always_comb begin
    low         = '0;
    low[B_HALT] = q_i.halt;
    low[B_RST]  = q_i.rst;
    low[B_HIRQ] = q_i.pend;
    low[B_EN]   = q_i.en;
  end

  // bank sits on a half-megabyte boundary: low two bits forced to zero
  assign stat_word = {bank_i[BANK_W-1:2], 2'b00, low};
  assign rdata_o   = rd_hit_i ? stat_word : '0;

  assign ipl_o = q_i.pwr_low ? IPL_PWRL  :
                 q_i.opcom   ? IPL_OPCOM : IPL_NONE;

  // R9
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit_i |-> (rdata_o == '0));
  // R5
  ipl_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_i.pwr_low |-> (ipl_o == 3'd7));
  // R8
  bank_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[9:8] == 2'b00);
endmodule

// File: rtl/nic_hcsr.sv
module nic_hcsr
  import nic_hcsr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SEL_W     = 2,
  parameter int BANK_W    = 8,
  parameter int BASE_ADDR = 'o140360,
  parameter int STRIDE    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              lp_irq_set_i,
  output logic              lp_halt_o,
  output logic              lp_reset_o,
  output logic [2:0]        lp_ipl_o,
  output logic              chk_dis_o,
  output logic              host_irq_o
);
  logic  ctrl_hit, stat_hit;
  ctrl_t q;

  nic_hcsr_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
  ) u_decode (
    .clk_i, .rst_ni, .sel_i, .addr_i,
    .ctrl_hit_o(ctrl_hit), .stat_hit_o(stat_hit)
  );

  nic_hcsr_ctrl u_ctrl (
    .clk_i, .rst_ni, .mclr_i,
    .wr_en_i  (wr_i && ctrl_hit),
    .wdata_i,
    .irq_set_i(lp_irq_set_i),
    .q_o      (q)
  );

  nic_hcsr_stat #(.BANK_W(BANK_W)) u_stat (
    .clk_i, .rst_ni,
    .rd_hit_i(rd_i && stat_hit),
    .bank_i,
    .q_i     (q),
    .rdata_o,
    .ipl_o   (lp_ipl_o)
  );

  assign lp_halt_o  = q.halt;
  assign lp_reset_o = q.rst;
  assign chk_dis_o  = q.chk_dis;
  assign host_irq_o = q.pend && q.en;

  // R7
  host_irq_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && stat_hit && host_irq_o) |-> (rdata_o[B_EN] && rdata_o[B_HIRQ]));
  // R9
  ctrl_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ctrl_hit) |-> (rdata_o == '0));
endmodule

// File: tb/nic_hcsr_bench.sv
module nic_hcsr_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mclr_i = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [7:0]  bank_i = 8'hA7;
  logic        lp_irq_set_i = 1'b0;
  logic        lp_halt_o, lp_reset_o, chk_dis_o, host_irq_o;
  logic [2:0]  lp_ipl_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  localparam logic [15:0] B0 = 16'o140360;
  localparam logic [15:0] B1 = 16'o140364;

  always #5 clk = ~clk;

  nic_hcsr u_nic_hcsr (
    .clk_i(clk), .rst_ni, .mclr_i, .sel_i, .addr_i, .wr_i, .rd_i, .wdata_i,
    .rdata_o, .bank_i, .lp_irq_set_i, .lp_halt_o, .lp_reset_o, .lp_ipl_o,
    .chk_dis_o, .host_irq_o
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    cyc();
    wr_i = 1'b0;
  endtask

  // driver: push expected read value, then strobe
  task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    addr_i = a; rd_i = 1'b1;
    cyc();
    rd_i = 1'b0;
  endtask

  task automatic pulse_set();
    lp_irq_set_i = 1'b1;
    cyc();
    lp_irq_set_i = 1'b0;
  endtask

  // monitor: compare read data mid-cycle
  always @(negedge clk) begin
    if (rd_i) begin
      item_t it;
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: actual %h expected none", rdata_o);
      end else begin
        it = sb_q.pop_front();
        chk(rdata_o, it.exp, it.tag);
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    cyc();
    // R2 reset state
    chk({15'd0, lp_halt_o},  16'd1, "R2 halt after reset");
    chk({15'd0, lp_reset_o}, 16'd1, "R2 reset after reset");
    chk({15'd0, host_irq_o}, 16'd0, "R7 irq after reset");
    rd(B0, 16'hA430, "R8 status after reset");
    rd(B0 + 16'd2, 16'hA430, "R1 status alias");

    // R3 start
    wr(B0 + 16'd1, 16'h0000);
    chk({14'd0, lp_halt_o, lp_reset_o}, 16'd0, "R3 released");
    rd(B0, 16'hA400, "R3 status after start");
    wr(B0 + 16'd3, 16'h0020);
    chk({14'd0, lp_halt_o, lp_reset_o}, 16'd2, "R1 R3 halt only via alias");

    // R4 layout, unused bits set
    wr(B0 + 16'd1, 16'hFFCF);
    chk({15'd0, chk_dis_o}, 16'd1, "R4 check disable");
    chk({13'd0, lp_ipl_o}, 16'd7, "R5 ipl power-low");
    chk({15'd0, host_irq_o}, 16'd0, "R6 bit2=1 leaves pend clear");
    rd(B0, 16'hA401, "R4 R8 status unused bits zero");

    // R6 set, R7 irq
    pulse_set();
    chk({15'd0, host_irq_o}, 16'd1, "R7 irq pend and en");
    rd(B0 + 16'd2, 16'hA405, "R6 pend in status");
    wr(B0 + 16'd1, 16'h0009);
    chk({13'd0, lp_ipl_o}, 16'd6, "R5 ipl opcom");
    chk({15'd0, host_irq_o}, 16'd0, "R6 clear by bit2=0");
    chk({15'd0, chk_dis_o}, 16'd0, "R4 check disable cleared");
    wr(B0 + 16'd1, 16'h0000);
    chk({13'd0, lp_ipl_o}, 16'd0, "R5 ipl none");

    // R6 set and clear in same cycle
    addr_i = B0 + 16'd1; wdata_i = 16'h0001; wr_i = 1'b1; lp_irq_set_i = 1'b1;
    cyc();
    wr_i = 1'b0; lp_irq_set_i = 1'b0;
    chk({15'd0, host_irq_o}, 16'd1, "R6 set wins over clear");
    wr(B0 + 16'd1, 16'h0005);
    chk({15'd0, host_irq_o}, 16'd1, "R6 bit2=1 keeps pend");
    wr(B0 + 16'd1, 16'h0001);
    chk({15'd0, host_irq_o}, 16'd0, "R6 later clear");

    // R7 enable gating
    pulse_set();
    wr(B0 + 16'd1, 16'h0004);
    chk({15'd0, host_irq_o}, 16'd0, "R7 disabled hides pend");
    rd(B0, 16'hA404, "R7 pend held while disabled");

    // R9 ignored accesses
    wr(B0, 16'h0031);
    rd(B0, 16'hA404, "R9 write to status ignored");
    rd(B0 + 16'd1, 16'h0000, "R9 read of control zero");
    sel_i = 2'd1;
    wr(B0 + 16'd1, 16'h0030);
    chk({14'd0, lp_halt_o, lp_reset_o}, 16'd0, "R1 other board ignored");
    rd(B0, 16'h0000, "R1 other board read zero");
    rd(B1 + 16'd2, 16'hA404, "R1 board 1 status");
    wr(B1 + 16'd1, 16'h0010);
    chk({14'd0, lp_halt_o, lp_reset_o}, 16'd1, "R1 board 1 control");
    rd(B1 + 16'd4, 16'h0000, "R1 outside window");

    // R8 bank low bits
    bank_i = 8'hFF;
    rd(B1, 16'hFC10, "R8 bank low bits zero");

    // R2 master clear beats write and set
    wr(B1 + 16'd1, 16'h0145);
    pulse_set();
    mclr_i = 1'b1; addr_i = B1 + 16'd1; wdata_i = 16'h0001; wr_i = 1'b1; lp_irq_set_i = 1'b1;
    cyc();
    mclr_i = 1'b0; wr_i = 1'b0; lp_irq_set_i = 1'b0;
    chk({14'd0, lp_halt_o, lp_reset_o}, 16'd3, "R2 mclr parks");
    chk({12'd0, chk_dis_o, lp_ipl_o}, 16'd0, "R2 mclr clears flags");
    chk({15'd0, host_irq_o}, 16'd0, "R2 mclr clears irq");
    rd(B1, 16'hFC30, "R2 status after mclr");

    cyc();
    done = 1'b1;
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    report();
  end
endmodule